// File: doc/BRIEF.md
# Two-Sided Word Mailbox

This block connects two processors, called side A and side B, that run on a common clock. Each side has its own small register bank on a word-addressed bus with a select, a write strobe, a 4-bit word address and 32-bit data. Each direction has four independent one-word channels. A word that one side writes into its transmit register n is latched for the other side and can be read there from receive register n. Status bits report, for each channel, whether the sender may write and whether the receiver has a word waiting. Software is expected to poll or to take an interrupt on these bits.

Every channel is a two-state machine. It starts in EMPTY. A load from the sender moves it EMPTY→FULL. A take, which is a read of the receive register by the receiver, moves it FULL→EMPTY. A load in FULL keeps it FULL and replaces the word (FULL→FULL), and this still holds when a take falls in the same cycle. A take in EMPTY keeps it EMPTY (EMPTY→EMPTY). Each side can also send four general requests to its peer, which raise sticky pending bits there. A control register holds enables for three interrupt sources: receive-full, transmit-empty and general request. It also holds three flag bits that are passed straight to the peer. Each side has one interrupt line.

Top module: `msg_mailbox`

## Requirements
- R1: After reset every channel is EMPTY. Each side's status reads 0x00F00000, its control reads 0, its interrupt is low and its peer-flag output is 0.
- R2: A write to word offset n (0..3) on one side stores the word for the peer. From the next cycle, the peer's offset 4+n returns that word, the peer's status bit 27−n (receive full) is 1, and the writer's status bit 23−n (transmit empty) is 0.
- R3: A read of offset 4+n on the receiving side empties channel n from the next cycle. This clears that side's bit 27−n and sets the sender's bit 23−n. If the sender loads the same channel in the same cycle, the channel stays full and holds the new word, and the read returns the old word.
- R4: Bus reads take no wait states. Offsets 0..3 and 10..15 read as 0, and writes to offsets 10..15 have no effect.
- R5: The control register (offset 9) keeps general enables in bits 31:28, receive enables in bits 27:24 and transmit enables in bits 23:20. Index n sits at the top bit of its field minus n. Flag bits are in 2:0. Bits 15:3 read as 0.
- R6: Writing 1 to control bit 19−n sets the peer's pending bit 31−n in status from the next cycle. Until the peer clears it, the writer's control bit 19−n reads 1.
- R7: Writing 1 to status bit 31−n clears this side's pending bit n. If the peer requests the same bit in the same cycle, the bit stays set.
- R8: A side's interrupt is high exactly when some status bit in 31:20 is 1 and the control bit at the same position is also 1.
- R9: The flag bits 2:0 written to one side's control register appear on the peer's flag output and in the peer's status bits 2:0.
- R10: Writes to receive offsets 4..7 and to status bits 27:0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_sel | input | 1 | Side A bus access this cycle |
| a_wr | input | 1 | Side A access is a write (0 = read) |
| a_addr | input | 4 | Side A word offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, same cycle |
| a_irq | output | 1 | Side A interrupt |
| a_peer_flags | output | 3 | Flag bits set by side B |
| b_sel | input | 1 | Side B bus access this cycle |
| b_wr | input | 1 | Side B access is a write (0 = read) |
| b_addr | input | 4 | Side B word offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, same cycle |
| b_irq | output | 1 | Side B interrupt |
| b_peer_flags | output | 3 | Flag bits set by side A |

## Verification
Two pairs of events can fall in the same cycle. The first is a load and a take on one full channel. The second is a general request from one side together with a clear of that same pending bit by its owner. Directed cycles drive both bus sides in one cycle to provoke each pair. For the channel, the bench expects the read to return the old word and the channel to stay full with the new one. For the pending bit, it expects the bit to survive. Random traffic on both sides then makes these collisions happen again, and a bench model that applies clears before sets judges every read, interrupt and flag output.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int AW  = 4;
    localparam int FLW = 3;

    localparam int GP_TOP  = 31;
    localparam int RF_TOP  = 27;
    localparam int TE_TOP  = 23;
    localparam int GIR_TOP = 19;
    localparam int IRQ_LO  = TE_TOP - NCH + 1;

    localparam int OFF_RX   = NCH;
    localparam int OFF_STAT = 2 * NCH;
    localparam int OFF_CTRL = 2 * NCH + 1;

    localparam logic [DW-1:0] CTRL_KEEP = 32'hFFF0_0007;

    typedef enum logic {
        CH_EMPTY = 1'b0,
        CH_FULL  = 1'b1
    } ch_state_t;
endpackage

// File: rtl/mbx_chan.sv
module mbx_chan
    import mbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          take,
    input  logic [DW-1:0] din,
    output logic          full,
    output logic [DW-1:0] dout
);
    ch_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            CH_EMPTY: if (load) nxt = CH_FULL;
            CH_FULL:  if (take && !load) nxt = CH_EMPTY;
            default:  nxt = CH_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_EMPTY;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

    always_comb full = (state == CH_FULL);

    // R2: a load always leaves the channel holding a word
    a_r2_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full);
    // R3: a take without a load empties it
    a_r3_take_drains: assert property (@(posedge clk) disable iff (!rst_n)
        take && !load |=> !full);
    // R3: the stored word only moves on a load
    a_r3_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));
endmodule

// File: rtl/mbx_side.sv
module mbx_side
    import mbx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel,
    input  logic                    wr,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    output logic                    irq,
    input  logic [NCH-1:0]          tx_full,
    input  logic [NCH-1:0]          rx_full,
    input  logic [NCH-1:0][DW-1:0]  rx_data,
    input  logic [NCH-1:0]          gir_in,
    output logic [NCH-1:0]          gir_out,
    input  logic [NCH-1:0]          peer_pend,
    output logic [NCH-1:0]          pend,
    input  logic [FLW-1:0]          peer_flags,
    output logic [FLW-1:0]          own_flags,
    output logic [NCH-1:0]          tx_load,
    output logic [NCH-1:0]          rx_take
);
    logic          wr_stb, rd_stb, stat_wr, ctrl_wr;
    logic [NCH-1:0] pclr;
    logic [DW-1:0] ctrl_q, stat_v, ctrl_v;

    always_comb begin
        wr_stb  = sel && wr;
        rd_stb  = sel && !wr;
        stat_wr = wr_stb && (addr == AW'(OFF_STAT));
        ctrl_wr = wr_stb && (addr == AW'(OFF_CTRL));
        for (int n = 0; n < NCH; n++) begin
            tx_load[n] = wr_stb && (addr == AW'(n));
            rx_take[n] = rd_stb && (addr == AW'(OFF_RX + n));
            gir_out[n] = ctrl_wr && wdata[GIR_TOP - n];
            pclr[n]    = stat_wr && wdata[GP_TOP - n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wdata & CTRL_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~pclr) | gir_in;
    end

    always_comb begin
        stat_v = '0;
        ctrl_v = ctrl_q;
        for (int n = 0; n < NCH; n++) begin
            stat_v[GP_TOP - n]  = pend[n];
            stat_v[RF_TOP - n]  = rx_full[n];
            stat_v[TE_TOP - n]  = !tx_full[n];
            ctrl_v[GIR_TOP - n] = peer_pend[n];
        end
        stat_v[FLW-1:0] = peer_flags;
        own_flags       = ctrl_q[FLW-1:0];
    end

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(OFF_STAT): rdata = stat_v;
            AW'(OFF_CTRL): rdata = ctrl_v;
            default: begin
                for (int n = 0; n < NCH; n++)
                    if (addr == AW'(OFF_RX + n)) rdata = rx_data[n];
            end
        endcase
    end

    always_comb irq = |(ctrl_q[GP_TOP:IRQ_LO] & stat_v[GP_TOP:IRQ_LO]);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_pchk
            // R7: a peer request wins over a same-cycle clear
            a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                gir_in[g] |=> pend[g]);
            // R7: an uncontested clear takes effect
            a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
                pclr[g] && !gir_in[g] |=> !pend[g]);
        end
    endgenerate

    // R8: nothing enabled means no interrupt
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[GP_TOP:IRQ_LO] == '0) |-> !irq);
    // R5: reserved control bits never take a value
    a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_q[15:FLW] == '0));
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
    import mbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_sel,
    input  logic          a_wr,
    input  logic [3:0]    a_addr,
    input  logic [31:0]   a_wdata,
    output logic [31:0]   a_rdata,
    output logic          a_irq,
    output logic [2:0]    a_peer_flags,
    input  logic          b_sel,
    input  logic          b_wr,
    input  logic [3:0]    b_addr,
    input  logic [31:0]   b_wdata,
    output logic [31:0]   b_rdata,
    output logic          b_irq,
    output logic [2:0]    b_peer_flags
);
    logic [NCH-1:0]          ab_full, ba_full;
    logic [NCH-1:0][DW-1:0]  ab_data, ba_data;
    logic [NCH-1:0]          a_load, a_take, b_load, b_take;
    logic [NCH-1:0]          a_gir, b_gir, a_pend, b_pend;
    logic [FLW-1:0]          a_flags, b_flags;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            mbx_chan u_ab (
                .clk(clk), .rst_n(rst_n), .load(a_load[g]), .take(b_take[g]),
                .din(a_wdata), .full(ab_full[g]), .dout(ab_data[g]));
            mbx_chan u_ba (
                .clk(clk), .rst_n(rst_n), .load(b_load[g]), .take(a_take[g]),
                .din(b_wdata), .full(ba_full[g]), .dout(ba_data[g]));
        end
    endgenerate

    mbx_side u_side_a (
        .clk(clk), .rst_n(rst_n), .sel(a_sel), .wr(a_wr), .addr(a_addr),
        .wdata(a_wdata), .rdata(a_rdata), .irq(a_irq),
        .tx_full(ab_full), .rx_full(ba_full), .rx_data(ba_data),
        .gir_in(b_gir), .gir_out(a_gir), .peer_pend(b_pend), .pend(a_pend),
        .peer_flags(b_flags), .own_flags(a_flags),
        .tx_load(a_load), .rx_take(a_take));

    mbx_side u_side_b (
        .clk(clk), .rst_n(rst_n), .sel(b_sel), .wr(b_wr), .addr(b_addr),
        .wdata(b_wdata), .rdata(b_rdata), .irq(b_irq),
        .tx_full(ba_full), .rx_full(ab_full), .rx_data(ab_data),
        .gir_in(a_gir), .gir_out(b_gir), .peer_pend(a_pend), .pend(b_pend),
        .peer_flags(a_flags), .own_flags(b_flags),
        .tx_load(b_load), .rx_take(b_take));

    always_comb begin
        a_peer_flags = b_flags;
        b_peer_flags = a_flags;
    end
endmodule

// File: tb/test_msg_mailbox.sv
`timescale 1ns/1ps
module test_msg_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
    logic [3:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;
    logic [2:0]  a_peer_flags, b_peer_flags;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    msg_mailbox i_msg_mailbox (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq), .a_peer_flags(a_peer_flags),
        .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq), .b_peer_flags(b_peer_flags));

    // model: index 0 = side A, 1 = side B; m_full[s] = channels sent by s
    logic [3:0]  m_full [2];
    logic [31:0] m_data [2][4];
    logic [31:0] m_ctrl [2];
    logic [3:0]  m_pend [2];

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat(input int s);
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++) begin
            v[31-n] = m_pend[s][n];
            v[27-n] = m_full[1-s][n];
            v[23-n] = !m_full[s][n];
        end
        v[2:0] = m_ctrl[1-s][2:0];
        return v;
    endfunction

    function automatic logic [31:0] exp_ctrl(input int s);
        logic [31:0] v = m_ctrl[s];
        for (int n = 0; n < 4; n++) v[19-n] = m_pend[1-s][n];
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input int s, input logic [3:0] a);
        if (a >= 4 && a <= 7) return m_data[1-s][a-4];
        if (a == 8) return exp_stat(s);
        if (a == 9) return exp_ctrl(s);
        return 32'h0;
    endfunction

    function automatic logic exp_irq(input int s);
        logic [31:0] st = exp_stat(s);
        return |(m_ctrl[s][31:20] & st[31:20]);
    endfunction

    function automatic string req_of(input logic [3:0] a);
        if (a >= 4 && a <= 7) return "R2";
        if (a == 8) return "R7";
        if (a == 9) return "R6";
        return "R4";
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            m_full[s] = '0; m_ctrl[s] = '0; m_pend[s] = '0;
            for (int n = 0; n < 4; n++) m_data[s][n] = '0;
        end
    endtask

    // clears first, then sets: sets win
    task automatic model_step(input logic [1:0] sel, input logic [1:0] wr,
                              input logic [3:0] ad [2], input logic [31:0] wd [2]);
        for (int s = 0; s < 2; s++) begin
            if (sel[s] && !wr[s] && ad[s] >= 4 && ad[s] <= 7) m_full[1-s][ad[s]-4] = 1'b0;
            if (sel[s] && wr[s] && ad[s] == 8)
                for (int n = 0; n < 4; n++) if (wd[s][31-n]) m_pend[s][n] = 1'b0;
        end
        for (int s = 0; s < 2; s++) begin
            if (sel[s] && wr[s] && ad[s] < 4) begin
                m_full[s][ad[s]] = 1'b1;
                m_data[s][ad[s]] = wd[s];
            end
            if (sel[s] && wr[s] && ad[s] == 9) begin
                m_ctrl[s] = wd[s] & 32'hFFF0_0007;
                for (int n = 0; n < 4; n++) if (wd[s][19-n]) m_pend[1-s][n] = 1'b1;
            end
        end
    endtask

    task automatic cyc(input logic [1:0] sel, input logic [1:0] wr,
                       input logic [3:0] ad0, input logic [31:0] wd0,
                       input logic [3:0] ad1, input logic [31:0] wd1,
                       input string tag);
        logic [3:0]  ad [2];
        logic [31:0] wd [2];
        ad[0] = ad0; ad[1] = ad1; wd[0] = wd0; wd[1] = wd1;
        @(negedge clk);
        a_sel = sel[0]; a_wr = wr[0]; a_addr = ad0; a_wdata = wd0;
        b_sel = sel[1]; b_wr = wr[1]; b_addr = ad1; b_wdata = wd1;
        #1;
        for (int s = 0; s < 2; s++) begin
            if (sel[s] && !wr[s])
                chk(tag == "" ? req_of(ad[s]) : tag, s ? b_rdata : a_rdata, exp_read(s, ad[s]));
            chk("R8 irq", {31'b0, s ? b_irq : a_irq}, {31'b0, exp_irq(s)});
            chk("R9 flags", {29'b0, s ? b_peer_flags : a_peer_flags}, {29'b0, m_ctrl[1-s][2:0]});
        end
        @(posedge clk);
        model_step(sel, wr, ad, wd);
    endtask

    task automatic rnd_op(output logic sel, output logic wr, output logic [3:0] ad,
                          output logic [31:0] wd);
        int r = int'($urandom % 10);
        sel = 1'b1; wr = 1'b0; wd = $urandom;
        ad = 4'(($urandom % 4));
        case (r)
            0, 1, 2: wr = 1'b1;
            3, 4:    ad = ad + 4'd4;
            5:       ad = 4'd8;
            6:       ad = 4'd9;
            7: begin wr = 1'b1; ad = 4'd9; if ($urandom % 2 == 0) wd[19:16] = 4'h0; end
            8: begin wr = 1'b1; ad = 4'd8; end
            default: begin ad = 4'(10 + ($urandom % 6)); wr = 1'($urandom % 2); sel = 1'($urandom % 2); end
        endcase
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20251));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        cyc(2'b11, 2'b00, 4'd8, 0, 4'd8, 0, "R1");
        cyc(2'b11, 2'b00, 4'd9, 0, 4'd9, 0, "R1");
        chk("R1 stat const", exp_stat(0), 32'h00F0_0000);

        // R2 handshake on channel 2, A to B
        cyc(2'b01, 2'b01, 4'd2, 32'hCAFE_0002, 4'd0, 0, "R2");
        cyc(2'b11, 2'b00, 4'd8, 0, 4'd8, 0, "R2");
        chk("R2 full bit", exp_stat(1) & 32'h0200_0000, 32'h0200_0000);
        cyc(2'b10, 2'b00, 4'd0, 0, 4'd6, 0, "R2");
        cyc(2'b11, 2'b00, 4'd8, 0, 4'd8, 0, "R3");

        // R3 load and take in one cycle on a full channel
        cyc(2'b01, 2'b01, 4'd1, 32'h1111_1111, 4'd0, 0, "R3");
        cyc(2'b11, 2'b01, 4'd1, 32'h2222_2222, 4'd5, 0, "R3");
        cyc(2'b10, 2'b00, 4'd0, 0, 4'd8, 0, "R3");
        cyc(2'b10, 2'b00, 4'd0, 0, 4'd5, 0, "R3");
        chk("R3 emptied", {31'b0, m_full[0][1]}, 32'd0);

        // R10 writes to receive offsets and read-only status bits
        cyc(2'b10, 2'b10, 4'd0, 0, 4'd5, 32'hDEAD_BEEF, "R10");
        cyc(2'b10, 2'b10, 4'd0, 0, 4'd8, 32'h0FFF_FFFF, "R10");
        cyc(2'b11, 2'b00, 4'd8, 0, 4'd8, 0, "R10");
        cyc(2'b01, 2'b00, 4'd5, 0, 4'd0, 0, "R10");

        // R4 unmapped and transmit offsets
        cyc(2'b01, 2'b01, 4'd12, 32'hFFFF_FFFF, 4'd0, 0, "R4");
        cyc(2'b11, 2'b00, 4'd12, 0, 4'd15, 0, "R4");
        cyc(2'b01, 2'b00, 4'd0, 0, 4'd0, 0, "R4");

        // R5, R6, R9 full control write on A
        cyc(2'b01, 2'b01, 4'd9, 32'hFFFF_FFFF, 4'd0, 0, "R5");
        cyc(2'b11, 2'b00, 4'd9, 0, 4'd8, 0, "R6");
        chk("R5 ctrl value", exp_ctrl(0), 32'hFFFF_0007);
        chk("R9 status flags", exp_stat(1) & 32'h7, 32'h7);

        // R7 set on bit 28 from A while B clears it
        cyc(2'b11, 2'b11, 4'd9, 32'hFFF1_0007, 4'd8, 32'h1000_0000, "R7");
        cyc(2'b10, 2'b00, 4'd0, 0, 4'd8, 0, "R7");
        cyc(2'b10, 2'b10, 4'd0, 0, 4'd8, 32'hF000_0000, "R7");
        cyc(2'b11, 2'b00, 4'd9, 0, 4'd8, 0, "R7");

        // R8 receive-full interrupt on B channel 0 (enable bit 27)
        cyc(2'b10, 2'b10, 4'd0, 0, 4'd9, 32'h0800_0000, "R8");
        cyc(2'b01, 2'b01, 4'd0, 32'h0BAD_F00D, 4'd0, 0, "R8");
        chk("R8 expect high", {31'b0, exp_irq(1)}, 32'd1);
        cyc(2'b10, 2'b00, 4'd0, 0, 4'd4, 0, "R8");
        cyc(2'b00, 2'b00, 4'd0, 0, 4'd0, 0, "R8");

        // random traffic on both sides
        for (int i = 0; i < 5000; i++) begin
            logic s0, w0, s1, w1;
            logic [3:0] a0, a1;
            logic [31:0] d0, d1;
            rnd_op(s0, w0, a0, d0);
            rnd_op(s1, w1, a1, d1);
            cyc({s1, s0}, {w1, w0}, a0, d0, a1, d1, "");
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule